// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block brings a USB 2.0 PHY out of standby and puts it back, on behalf of several software or hardware clients that share it. Clients raise a start-up or power-down request; the block keeps a use count and runs the register sequence only on the first start-up and on the last power-down. Other requests only move the count. Board straps give the port-1 role, the level of the port-1 power-enable pin, the overcurrent pin select and polarity of three ports, a ferrite-bead option, and whether the optional signal-quality register block exists.

All PHY access goes over two small ports. A write port carries an address and a 32-bit data word with a valid/ready handshake. A read port polls the status register the same way. The start-up turns on the PHY supply, then the PLL, and writes the signal-quality tuning when present. It then waits a settle interval and polls the status word until it reads exactly bits 31 and 30 set, or until the retry limit runs out. On success it releases the PHY reset, writes the port configuration word and sets both host controllers to little-endian bus alignment. The block reports the end of each sequence with a one-cycle `done` pulse and a separate sticky error flag.

States: `S_IDLE` (waiting; takes requests), `S_PWR_ON`, `S_PLL_ON`, `S_SQ_A`, `S_SQ_B`, `S_RST_REL`, `S_PORT_CFG`, `S_ALIGN_EH`, `S_ALIGN_OH`, `S_PWR_OFF` (each issues one write and moves on when it is accepted), `S_SETTLE` (counts the settle interval), `S_POLL` (one status read) and `S_FINISH` (pulses `done`). Transitions:
- `S_IDLE` goes to `S_PWR_ON` on an accepted start-up with count 0, and to `S_PWR_OFF` on an accepted power-down with count 1.
- `S_PWR_ON` goes to `S_PLL_ON`.
- `S_PLL_ON` goes to `S_SQ_A` when the signal-quality block is present, otherwise to `S_SETTLE`.
- `S_SQ_A` goes to `S_SQ_B`, and `S_SQ_B` goes to `S_SETTLE`.
- `S_SETTLE` goes to `S_POLL` when the interval expires.
- `S_POLL` goes to `S_RST_REL` on a matching read. A non-matching read goes to `S_SETTLE`, or to `S_FINISH` if it was the last allowed try.
- `S_RST_REL`, `S_PORT_CFG`, `S_ALIGN_EH` and `S_ALIGN_OH` follow each other and end in `S_FINISH`.
- `S_PWR_OFF` goes to `S_FINISH`, and `S_FINISH` goes to `S_IDLE`.

Top module: `usbphy_pwrseq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `wr_valid` and `rd_valid` are 0 and `use_count` is 0; while `busy` is 0 no write or read is issued.
- R2: A start-up request accepted with count 0 raises the count to 1 and first writes 0x00000001 then 0x00000003 to address 0x04 (bit 0 PHY supply enable, bit 1 PLL enable, bit 2 reset release).
- R3: When `cfg_sq_present` is 1, the next two writes go to 0x24 (0x41 with `cfg_bead`=1, 0x00 otherwise) and to 0x28 (0x0D with `cfg_bead`=1, 0x07 otherwise); when it is 0, neither address is written.
- R4: Every status read targets address 0x08 and is preceded by exactly WAIT_CYCLES idle cycles, with WAIT_CYCLES = CLK_HZ/1000*WAIT_US/1000 (minimum 1). Only the value 0xC0000000 counts as ready; any other value, including 0xC0000001, leads to another try.
- R5: On a ready status the block writes, in order, 0x00000007 to 0x04, the port configuration word to 0x00, 0x00000000 to 0x0C and 0x00000000 to 0x1C. It then pulses `done` for one cycle with `err` at 0 and drops `busy` in the next cycle.
- R6: The port configuration word has bit 0 = `cfg_port1_func`, bit 4 = `cfg_pen_high`, bits 8, 9 and 10 = `cfg_ovc_sel[0..2]`, and the active-high polarity of ports 0, 1 and 2 in bits 3, 1 and 6; all other bits are 0.
- R7: After MAX_TRIES reads without a match the sequence issues no further write, pulses `done` with `err` = 1 and leaves `use_count` at 1; `err` stays set until the next start-up sequence begins.
- R8: A start-up request accepted with a nonzero count only adds 1 to the count, with no bus access, no `busy` and no `done`.
- R9: A power-down request decrements the count. Going from 1 to 0 writes 0x00000000 to 0x04 and pulses `done`; from a higher count there is no bus access. With count 0 the request is ignored.
- R10: Requests are only taken while `busy` is 0. A request held during a running sequence leaves the count unchanged until the sequence ends, and is then taken. When both requests are present, start-up is taken first.
- R11: Each write holds `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready`. At most one write or read is outstanding at any time.
- R12: The count saturates at 2^CNT_W-1; a start-up request at that value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start-up request, held until taken |
| shut_req | input | 1 | Power-down request, held until taken |
| cfg_port1_func | input | 1 | Port 1 in device role |
| cfg_pen_high | input | 1 | Port-1 power-enable pin driven high |
| cfg_ovc_sel | input | 3 | Overcurrent pin select, ports 0..2 |
| cfg_ovc_act_high | input | 3 | Overcurrent active-high, ports 0..2 |
| cfg_bead | input | 1 | Ferrite bead fitted |
| cfg_sq_present | input | 1 | Signal-quality registers exist |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data |
| wr_ready | input | 1 | Write accepted |
| rd_valid | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ready | input | 1 | Read done, `rd_data` valid |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last start-up timed out |
| use_count | output | CNT_W | Number of active users |

## Verification
A request seen at a falling edge is taken at the next rising edge. A count-only change shows up at the falling edge after that, and so does `busy` when a sequence starts. Each read comes WAIT_CYCLES+1 edges after the previous read's acceptance edge, and the bench measures that gap at every poll with a cycle counter. `done` follows one edge after the last accepted write or the final failing read, and `busy` drops one edge later. The bench therefore waits for `done` at falling edges, checks the pulse and the drop of `busy` at the next one, and compares the logged write list and read count with lists built by its own functions from the straps and the chosen status pattern.

// File: rtl/usbphy_pwrseq_pkg.sv
package usbphy_pwrseq_pkg;

    localparam int OVC_PORTS = 3;

    // register addresses
    localparam logic [7:0] OFS_PORTCFG = 8'h00;
    localparam logic [7:0] OFS_PWR     = 8'h04;
    localparam logic [7:0] OFS_STATUS  = 8'h08;
    localparam logic [7:0] OFS_ALIGN_E = 8'h0C;
    localparam logic [7:0] OFS_ALIGN_O = 8'h1C;
    localparam logic [7:0] OFS_SQ_A    = 8'h24;
    localparam logic [7:0] OFS_SQ_B    = 8'h28;

    localparam logic [31:0] STATUS_READY = 32'hC000_0000;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PWR_ON,
        S_PLL_ON,
        S_SQ_A,
        S_SQ_B,
        S_SETTLE,
        S_POLL,
        S_RST_REL,
        S_PORT_CFG,
        S_ALIGN_EH,
        S_ALIGN_OH,
        S_PWR_OFF,
        S_FINISH
    } seq_state_e;

    // power control word: bit0 supply, bit1 PLL, bit2 reset release
    function automatic logic [31:0] pwr_word(input logic sup, input logic pll, input logic rel);
        pwr_word = {29'd0, rel, pll, sup};
    endfunction

    // polarity bit positions are irregular across ports
    function automatic int unsigned ovc_pol_pos(input int unsigned port);
        unique case (port)
            0:       ovc_pol_pos = 3;
            1:       ovc_pol_pos = 1;
            default: ovc_pol_pos = 6;
        endcase
    endfunction

endpackage

// File: rtl/usbphy_settle_timer.sv
module usbphy_settle_timer #(
    parameter int WAIT_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES + 1) : 1;

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(WAIT_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/usbphy_use_counter.sv
module usbphy_use_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             is_zero,
    output logic             is_one,
    output logic             is_max
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    assign is_zero = (count == '0);
    assign is_one  = (count == CNT_W'(1));
    assign is_max  = (count == MAXV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !is_max) begin
            count <= count + 1'b1;
        end else if (dec && !is_zero) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/usbphy_portcfg_enc.sv
module usbphy_portcfg_enc
    import usbphy_pwrseq_pkg::*;
(
    input  logic                 port1_func,
    input  logic                 pen_high,
    input  logic [OVC_PORTS-1:0] ovc_sel,
    input  logic [OVC_PORTS-1:0] ovc_act_high,
    output logic [31:0]          word
);
    logic [31:0] sel_part;
    logic [31:0] pol_part [OVC_PORTS];

    // select bits are contiguous, polarity bits are scattered
    for (genvar g = 0; g < OVC_PORTS; g++) begin : g_port
        assign pol_part[g] = ovc_act_high[g] ? (32'd1 << ovc_pol_pos(g)) : 32'd0;
    end

    assign sel_part = {21'd0, ovc_sel, 8'd0};

    always_comb begin
        word = sel_part;
        word[0] = port1_func;
        word[4] = pen_high;
        for (int i = 0; i < OVC_PORTS; i++) begin
            word = word | pol_part[i];
        end
    end
endmodule

// File: rtl/usbphy_pwrseq.sv
module usbphy_pwrseq
    import usbphy_pwrseq_pkg::*;
#(
    parameter int CLK_HZ    = 250_000_000,
    parameter int WAIT_US   = 10,
    parameter int MAX_TRIES = 1024,
    parameter int CNT_W     = 4,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              shut_req,
    input  logic              cfg_port1_func,
    input  logic              cfg_pen_high,
    input  logic [2:0]        cfg_ovc_sel,
    input  logic [2:0]        cfg_ovc_act_high,
    input  logic              cfg_bead,
    input  logic              cfg_sq_present,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  use_count
);
    localparam int WAIT_RAW    = (CLK_HZ / 1000) * WAIT_US / 1000;
    localparam int WAIT_CYCLES = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
    localparam int TRY_W       = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    seq_state_e state, nxt;

    logic [TRY_W-1:0] tries;
    logic             err_q;
    logic             timer_run, timer_exp;
    logic             cnt_zero, cnt_one, cnt_max;
    logic             accept_init, accept_shut;
    logic             wr_fire, rd_fire, status_ok, last_try;
    logic [31:0]      port_word;

    // ---------------- sub-blocks ----------------
    usbphy_settle_timer #(.WAIT_CYCLES(WAIT_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .expired (timer_exp)
    );

    usbphy_use_counter #(.CNT_W(CNT_W)) i_users (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (accept_init),
        .dec     (accept_shut),
        .count   (use_count),
        .is_zero (cnt_zero),
        .is_one  (cnt_one),
        .is_max  (cnt_max)
    );

    usbphy_portcfg_enc i_enc (
        .port1_func   (cfg_port1_func),
        .pen_high     (cfg_pen_high),
        .ovc_sel      (cfg_ovc_sel),
        .ovc_act_high (cfg_ovc_act_high),
        .word         (port_word)
    );

    // ---------------- request arbitration ----------------
    assign accept_init = init_req && (state == S_IDLE) && !cnt_max;
    assign accept_shut = shut_req && (state == S_IDLE) && !accept_init && !cnt_zero;

    assign wr_fire   = wr_valid && wr_ready;
    assign rd_fire   = rd_valid && rd_ready;
    assign status_ok = (rd_data == STATUS_READY);
    assign last_try  = (tries == TRY_W'(MAX_TRIES - 1));

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept_init && cnt_zero)     nxt = S_PWR_ON;
                else if (accept_shut && cnt_one) nxt = S_PWR_OFF;
            end
            S_PWR_ON:   if (wr_fire) nxt = S_PLL_ON;
            S_PLL_ON:   if (wr_fire) nxt = cfg_sq_present ? S_SQ_A : S_SETTLE;
            S_SQ_A:     if (wr_fire) nxt = S_SQ_B;
            S_SQ_B:     if (wr_fire) nxt = S_SETTLE;
            S_SETTLE:   if (timer_exp) nxt = S_POLL;
            S_POLL: begin
                if (rd_fire) begin
                    if (status_ok)     nxt = S_RST_REL;
                    else if (last_try) nxt = S_FINISH;
                    else               nxt = S_SETTLE;
                end
            end
            S_RST_REL:  if (wr_fire) nxt = S_PORT_CFG;
            S_PORT_CFG: if (wr_fire) nxt = S_ALIGN_EH;
            S_ALIGN_EH: if (wr_fire) nxt = S_ALIGN_OH;
            S_ALIGN_OH: if (wr_fire) nxt = S_FINISH;
            S_PWR_OFF:  if (wr_fire) nxt = S_FINISH;
            S_FINISH:   nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // ---------------- retry counter and error flag ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tries <= '0;
            err_q <= 1'b0;
        end else if (state == S_IDLE && accept_init && cnt_zero) begin
            tries <= '0;
            err_q <= 1'b0;
        end else if (state == S_POLL && rd_fire && !status_ok) begin
            if (last_try) err_q <= 1'b1;
            else          tries <= tries + 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        wr_valid  = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        rd_valid  = 1'b0;
        rd_addr   = '0;
        timer_run = 1'b0;
        done      = 1'b0;
        busy      = (state != S_IDLE);
        unique case (state)
            S_IDLE: ;
            S_PWR_ON: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_PWR);
                wr_data  = pwr_word(1'b1, 1'b0, 1'b0);
            end
            S_PLL_ON: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_PWR);
                wr_data  = pwr_word(1'b1, 1'b1, 1'b0);
            end
            S_SQ_A: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_SQ_A);
                wr_data  = cfg_bead ? 32'h41 : 32'h00;
            end
            S_SQ_B: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_SQ_B);
                wr_data  = cfg_bead ? 32'h0D : 32'h07;
            end
            S_SETTLE: timer_run = 1'b1;
            S_POLL: begin
                rd_valid = 1'b1;
                rd_addr  = ADDR_W'(OFS_STATUS);
            end
            S_RST_REL: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_PWR);
                wr_data  = pwr_word(1'b1, 1'b1, 1'b1);
            end
            S_PORT_CFG: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_PORTCFG);
                wr_data  = port_word;
            end
            S_ALIGN_EH: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_ALIGN_E);
            end
            S_ALIGN_OH: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_ALIGN_O);
            end
            S_PWR_OFF: begin
                wr_valid = 1'b1;
                wr_addr  = ADDR_W'(OFS_PWR);
            end
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign err = err_q;

endmodule

// File: rtl/usbphy_pwrseq_chk.sv
module usbphy_pwrseq_chk #(
    parameter int CNT_W  = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [CNT_W-1:0]  use_count
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_valid && !rd_valid));

    assert_wr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_one_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && rd_valid));

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    assert_status_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_addr == ADDR_W'(8'h08)));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_err_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    assert_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(use_count) |-> !$past(busy));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(use_count) |->
            ((use_count == CNT_W'($past(use_count) + 1'b1)) ||
             (use_count == CNT_W'($past(use_count) - 1'b1))));

    assert_off_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr == ADDR_W'(8'h04) && wr_data == 32'd0) |-> (use_count == '0));
endmodule

bind usbphy_pwrseq usbphy_pwrseq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .use_count (use_count)
);

// File: tb/test_usbphy_pwrseq.sv
`timescale 1ns/1ps
module test_usbphy_pwrseq;
    localparam int CLK_HZ = 400_000;   // gives a 4-cycle settle interval
    localparam int WAIT_US = 10;
    localparam int WAITC = 4;
    localparam int TRIES = 8;
    localparam int CW = 3;
    localparam int AW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_req = 1'b0, shut_req = 1'b0;
    logic port1 = 1'b0, pen = 1'b0, bead = 1'b0, sqp = 1'b0;
    logic [2:0] osel = '0, oact = '0;
    logic wr_valid, rd_valid, busy, done, err;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic wr_ready = 1'b0, rd_ready = 1'b0;
    logic [31:0] rd_data = '0;
    logic [CW-1:0] use_count;

    always #2 clk = ~clk;   // 250 MHz

    usbphy_pwrseq #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .MAX_TRIES(TRIES),
                    .CNT_W(CW), .ADDR_W(AW)) i_usbphy_pwrseq (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .shut_req(shut_req),
        .cfg_port1_func(port1), .cfg_pen_high(pen), .cfg_ovc_sel(osel),
        .cfg_ovc_act_high(oact), .cfg_bead(bead), .cfg_sq_present(sqp),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .busy(busy), .done(done), .err(err), .use_count(use_count));

    int tests = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // bus model state
    logic [7:0]  log_a [32];
    logic [31:0] log_d [32];
    int log_n = 0;
    int poll_cnt = 0, good_after = 0;
    logic [31:0] bad_val = '0;
    int hold_errs = 0, gap_errs = 0, addr_errs = 0;
    bit seen_poll = 0, prev_rd = 0, pend_wr = 0;
    int last_rd_cyc = 0;
    logic [7:0] pw_a;
    logic [31:0] pw_d;

    logic [7:0]  exp_a [16];
    logic [31:0] exp_d [16];
    int exp_n = 0;

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // device model, driven away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_wr && !(wr_valid && wr_addr == pw_a && wr_data == pw_d)) hold_errs++;
            if (rd_valid && !prev_rd && seen_poll && (cyc - last_rd_cyc != WAITC + 1)) gap_errs++;
            if (rd_valid && rd_addr != 8'h08) addr_errs++;
            prev_rd = rd_valid;
            wr_ready = ($urandom % 3) != 0;
            if (wr_valid && wr_ready) begin
                if (log_n < 32) begin
                    log_a[log_n] = wr_addr;
                    log_d[log_n] = wr_data;
                end
                log_n++;
                pend_wr = 0;
            end else begin
                pend_wr = wr_valid;
                pw_a = wr_addr;
                pw_d = wr_data;
            end
            rd_ready = ($urandom % 3) != 0;
            rd_data = (poll_cnt < good_after) ? bad_val : 32'hC000_0000;
            if (rd_valid && rd_ready) begin
                poll_cnt++;
                seen_poll = 1;
                last_rd_cyc = cyc;
            end
        end
    end

    function automatic logic [31:0] exp_port_word();
        logic [31:0] w = '0;
        w[0] = port1; w[4] = pen;
        w[8] = osel[0]; w[9] = osel[1]; w[10] = osel[2];
        w[3] = oact[0]; w[1] = oact[1]; w[6] = oact[2];
        return w;
    endfunction

    task automatic push(input logic [7:0] a, input logic [31:0] d);
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
    endtask

    task automatic build_exp(input bit ok);
        exp_n = 0;
        push(8'h04, 32'h1); push(8'h04, 32'h3);
        if (sqp) begin
            push(8'h24, bead ? 32'h41 : 32'h00);
            push(8'h28, bead ? 32'h0D : 32'h07);
        end
        if (ok) begin
            push(8'h04, 32'h7); push(8'h00, exp_port_word());
            push(8'h0C, 32'h0); push(8'h1C, 32'h0);
        end
    endtask

    task automatic compare_log(input string req);
        int mism = 0;
        check(log_n == exp_n, req, "write count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_a[i] !== exp_a[i] || log_d[i] !== exp_d[i]) mism++;
        check(mism == 0, req, "write order/values", mism, 0);
    endtask

    task automatic req_init();
        @(negedge clk);
        while (busy) @(negedge clk);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
    endtask

    task automatic req_shut();
        @(negedge clk);
        while (busy) @(negedge clk);
        shut_req = 1'b1;
        @(negedge clk);
        shut_req = 1'b0;
    endtask

    task automatic wait_done(input string req, output bit err_seen);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(done, req, "done pulse", done, 1);
        err_seen = err;
        @(negedge clk);
        check(!done && !busy, req, "done one cycle, busy drops", {done, busy}, 0);
    endtask

    task automatic pick_cfg();
        logic [31:0] r = $urandom;
        port1 = r[0]; pen = r[1]; osel = r[4:2]; oact = r[7:5]; bead = r[8]; sqp = r[9];
        case ($urandom % 5)
            0: bad_val = 32'h0000_0000;
            1: bad_val = 32'h8000_0000;
            2: bad_val = 32'hC000_0001;
            3: bad_val = 32'h4000_0000;
            default: bad_val = $urandom | 32'h1;
        endcase
    endtask

    // start-up from count 0; ga = polls answered with a bad value first
    task automatic run_start(input int ga, input string req);
        bit e;
        bit ok = (ga < TRIES);
        good_after = ga;
        log_n = 0; poll_cnt = 0; seen_poll = 0;
        req_init();
        check(busy && use_count == 1, "R2", "count 1 and busy", use_count, 1);
        wait_done(req, e);
        build_exp(ok);
        compare_log(ok ? "R5/R6" : "R7");
        check(poll_cnt == (ok ? ga + 1 : TRIES), ok ? "R4" : "R7", "status reads",
              poll_cnt, ok ? ga + 1 : TRIES);
        check(e == !ok, ok ? "R5" : "R7", "err at done", e, !ok);
        check(use_count == 1, "R7", "count after start-up", use_count, 1);
    endtask

    task automatic run_last_off();
        bit e;
        log_n = 0;
        req_shut();
        wait_done("R9", e);
        check(log_n == 1 && log_a[0] == 8'h04 && log_d[0] == 32'h0, "R9",
              "power-off write", {log_a[0], log_d[0][23:0]}, {8'h04, 24'h0});
        check(use_count == 0, "R9", "count zero", use_count, 0);
    endtask

    initial begin
        bit e;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy && !done && !err && !wr_valid && !rd_valid && use_count == 0,
              "R1", "reset state", {busy, done, err, wr_valid, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: power-down at zero is ignored
        log_n = 0;
        req_shut();
        repeat (3) @(negedge clk);
        check(use_count == 0 && log_n == 0 && !busy, "R9", "shut at zero ignored", log_n, 0);

        // directed: immediate ready, signal-quality with bead
        pick_cfg(); sqp = 1; bead = 1;
        run_start(0, "R3");
        // R8: further start-up only counts
        log_n = 0;
        req_init();
        check(use_count == 2 && !busy && !done, "R8", "second user counted", use_count, 2);
        repeat (3) @(negedge clk);
        check(log_n == 0 && poll_cnt == 1, "R8", "no bus access", log_n, 0);
        req_shut();
        repeat (3) @(negedge clk);
        check(use_count == 1 && log_n == 0, "R9", "non-last shut", use_count, 1);
        run_last_off();

        // directed: near-match status then match
        pick_cfg(); sqp = 0; bad_val = 32'hC000_0001;
        good_after = 2;
        run_start(2, "R4");
        run_last_off();

        // directed: timeout, then later user, err held until next start
        pick_cfg(); sqp = 1; bead = 0;
        run_start(TRIES, "R7");
        log_n = 0;
        req_init();
        check(use_count == 2 && err && log_n == 0, "R7", "err held, count only", use_count, 2);
        req_shut();
        run_last_off();

        // R10: power-down held while a start-up runs
        pick_cfg(); good_after = 1;
        log_n = 0; poll_cnt = 0; seen_poll = 0;
        req_init();
        shut_req = 1'b1;
        begin
            int bad = 0;
            while (!done) begin
                @(negedge clk);
                if (use_count != 1) bad++;
            end
            check(bad == 0, "R10", "count held while busy", bad, 0);
        end
        @(negedge clk);           // idle: held request taken at next edge
        @(negedge clk);
        shut_req = 1'b0;
        check(use_count == 0 && busy, "R10", "held shut taken after sequence", use_count, 0);
        while (!done) @(negedge clk);
        @(negedge clk);
        check(log_a[log_n-1] == 8'h04 && log_d[log_n-1] == 32'h0, "R10", "off write after",
              log_d[log_n-1], 0);

        // R10: both requests at once, start-up first
        pick_cfg();
        run_start(0, "R10");
        @(negedge clk);
        init_req = 1'b1; shut_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        check(use_count == 2, "R10", "start-up wins", use_count, 2);
        @(negedge clk);
        shut_req = 1'b0;
        check(use_count == 1, "R10", "power-down next", use_count, 1);
        run_last_off();

        // R12: saturation
        pick_cfg();
        run_start(0, "R12");
        for (int i = 0; i < 7; i++) req_init();
        check(use_count == 7, "R12", "saturated count", use_count, 7);
        for (int i = 0; i < 6; i++) req_shut();
        run_last_off();

        // random mix
        for (int it = 0; it < 24; it++) begin
            pick_cfg();
            run_start($urandom % (TRIES + 2), "R6");
            run_last_off();
        end

        check(gap_errs == 0, "R4", "settle gap before reads", gap_errs, 0);
        check(addr_errs == 0, "R4", "status address", addr_errs, 0);
        check(hold_errs == 0, "R11", "write held until ready", hold_errs, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual %0d expected 0 cycles left", 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule